// File: doc/BRIEF.md
# Saturating Packed DSP Arithmetic Unit

This unit performs the small set of arithmetic operations that signal-processing inner loops lean on, all inside one 32-bit datapath. A plain add can treat the word as a single 32-bit value, as two independent 16-bit lanes or as four independent 8-bit lanes. The lanes are produced by cutting the carry chain of the one adder, so no second datapath is needed. A signed 32-bit add clamps to the representable range instead of wrapping.

A halfword multiply-accumulate picks the upper or lower signed 16 bits of each of two sources and adds their product to a third word. A byte-wise sum of absolute differences, used in block matching, can also be added to a running total.

Every operation is launched by `valid_i` and its result is registered, one cycle after launch. Between launches the outputs hold their last value. Instruction decode, operand fetch and condition handling belong to the surrounding pipeline.

Top module: `dsp_simd_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `ovf_o`, `lane_ge_o` and `valid_o` become 0.
- R2: A launch (`valid_i`=1 at a rising edge) updates `result_o`, `ovf_o` and `lane_ge_o` at that edge, and `valid_o` is 1 for that cycle. A cycle with `valid_i`=0 leaves `result_o`, `ovf_o` and `lane_ge_o` unchanged and clears `valid_o`.
- R3: Opcode 0 (add) with lane select 2'b00 returns (a+b) mod 2^32 with `ovf_o`=0, and `lane_ge_o` bit 0 holds the carry out of bit 31. For example, 0x70000000+0x7FFFFFFF gives 0xEFFFFFFF.
- R4: Opcode 1 (saturating add) clamps positive signed overflow to 0x7FFFFFFF and sets `ovf_o`. For example, 0x70000000+0x7FFFFFFF gives 0x7FFFFFFF.
- R5: Opcode 1 clamps negative signed overflow to 0x80000000 and sets `ovf_o`. Without overflow it returns the exact sum with `ovf_o`=0.
- R6: Opcode 0 with lane select 2'b01 adds two 16-bit lanes with no carry between them. `lane_ge_o[k]` is the carry out of halfword lane k (lane 0 is bits 15:0), and bits 3:2 are 0.
- R7: Opcode 0 with lane select 2'b10 or 2'b11 adds four 8-bit lanes with no carries between them. `lane_ge_o[k]` is the carry out of byte lane k (lane 0 is bits 7:0).
- R8: Opcode 2 (halfword multiply-accumulate) takes the signed halfword `a[31:16]` when `hi_a_i`=1 or `a[15:0]` when it is 0, and takes `b` the same way under `hi_b_i`. It returns c + product modulo 2^32.
- R9: Opcode 2 sets `ovf_o` exactly when the signed 32-bit accumulate overflows.
- R10: Opcode 3 returns the sum of the absolute differences of the four unsigned byte pairs of `a` and `b`, zero-extended to 32 bits, with `ovf_o`=0.
- R11: Opcode 4 returns c plus that byte sum modulo 2^32, with `ovf_o`=0.
- R12: Opcodes 5 to 7 return a result of 0 with `ovf_o`=0 and `lane_ge_o`=0. `lane_ge_o` is 0 for every opcode other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Launch an operation this cycle |
| op_i | input | 3 | Opcode: 0 add, 1 saturating add, 2 halfword MAC, 3 byte SAD, 4 byte SAD accumulate |
| lane_i | input | 2 | Lane width for opcode 0: 00 one 32-bit lane, 01 two 16-bit lanes, 1x four 8-bit lanes |
| hi_a_i | input | 1 | MAC: take the upper halfword of a |
| hi_b_i | input | 1 | MAC: take the upper halfword of b |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| c_i | input | 32 | Accumulate operand |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Clamp or overflow occurred for this result |
| lane_ge_o | output | 4 | Per-lane carry-out (unsigned greater-or-equal) bits of the packed add |
| valid_o | output | 1 | Result register was loaded in the last cycle |

## Verification
A lane boundary that leaks a carry shows up the cycle after a launch: the next lane's low bit is off by one, and that lane's ge bit moves to a different lane. Operand patterns are chosen so that every byte and halfword boundary either carries or must not carry. A wrong clamp decision flips `ovf_o` and turns a clamped value into a wrapped one in the same registered cycle. A wrong halfword selection or sign extension changes the MAC sum, so all four select combinations are run with a negative low halfword. A stale result register appears as a changed `result_o` during idle cycles, which the bench probes directly.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_QADD = 3'd1,
    OP_MAC  = 3'd2,
    OP_SAD  = 3'd3,
    OP_SADA = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    LN_W32 = 2'b00,
    LN_W16 = 2'b01,
    LN_W8  = 2'b10,
    LN_W8B = 2'b11
  } lane_e;
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [1:0]     lane_i,
  output logic [W-1:0]   sum_o,
  output logic [W/8-1:0] ge_o
);
  localparam int NB = W / 8;

  logic [NB-1:0] byte_cy;
  logic          w16, w8;

  assign w8  = lane_i[1];
  assign w16 = (lane_i == 2'b01);

  always_comb begin
    logic       cc;
    logic [8:0] part;
    cc = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (w8 || (w16 && (i % 2 == 0))) cc = 1'b0;
      part = {1'b0, a_i[8*i +: 8]} + {1'b0, b_i[8*i +: 8]} + {8'd0, cc};
      sum_o[8*i +: 8] = part[7:0];
      cc = part[8];
      byte_cy[i] = part[8];
    end
  end

  always_comb begin
    ge_o = '0;
    if (w8) begin
      ge_o = byte_cy;
    end else if (w16) begin
      for (int k = 0; k < NB / 2; k++) ge_o[k] = byte_cy[2*k+1];
    end else begin
      ge_o[0] = byte_cy[NB-1];
    end
  end
endmodule

// File: rtl/sat_add.sv
module sat_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;

  assign raw   = a_i + b_i;
  assign sat_o = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);
  assign res_o = sat_o ? (a_i[W-1] ? SMIN : SMAX) : raw;

  // R4 R5: a clamped value always carries the sign of the operands
  always_comb begin
    if (sat_o) begin
      a_r5_clamp_sign: assert (res_o[W-1] == b_i[W-1]);
    end
  end
endmodule

// File: rtl/half_mac.sv
module half_mac #(
  parameter int W = 32
) (
  input  logic         hi_a_i,
  input  logic         hi_b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int H = W / 2;

  logic signed [H-1:0] ha, hb;
  logic signed [W-1:0] prod;

  assign ha    = hi_a_i ? a_i[W-1:H] : a_i[H-1:0];
  assign hb    = hi_b_i ? b_i[W-1:H] : b_i[H-1:0];
  assign prod  = W'(ha) * W'(hb);
  assign res_o = c_i + prod;
  assign ovf_o = (c_i[W-1] == prod[W-1]) && (res_o[W-1] != c_i[W-1]);
endmodule

// File: rtl/byte_sad.sv
module byte_sad #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sad_o
);
  localparam int NB = W / 8;
  localparam int SW = 8 + $clog2(NB);

  logic [SW-1:0] acc;

  always_comb begin
    logic [7:0] d;
    acc = '0;
    for (int i = 0; i < NB; i++) begin
      d = (a_i[8*i +: 8] > b_i[8*i +: 8]) ? (a_i[8*i +: 8] - b_i[8*i +: 8])
                                           : (b_i[8*i +: 8] - a_i[8*i +: 8]);
      acc = acc + SW'(d);
    end
  end

  assign sad_o = W'(acc);
endmodule

// File: rtl/dsp_simd_alu.sv
module dsp_simd_alu #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_i,
  input  logic [2:0]     op_i,
  input  logic [1:0]     lane_i,
  input  logic           hi_a_i,
  input  logic           hi_b_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   c_i,
  output logic [W-1:0]   result_o,
  output logic           ovf_o,
  output logic [W/8-1:0] lane_ge_o,
  output logic           valid_o
);
  import dsp_alu_pkg::*;
  localparam int NB = W / 8;

  logic [W-1:0]  add_sum, q_sum, mac_sum, sad_sum;
  logic [NB-1:0] add_ge;
  logic          q_sat, mac_ovf;

  simd_lane_adder #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_i), .lane_i(lane_i), .sum_o(add_sum), .ge_o(add_ge)
  );
  sat_add #(.W(W)) u_qadd (
    .a_i(a_i), .b_i(b_i), .res_o(q_sum), .sat_o(q_sat)
  );
  half_mac #(.W(W)) u_mac (
    .hi_a_i(hi_a_i), .hi_b_i(hi_b_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .res_o(mac_sum), .ovf_o(mac_ovf)
  );
  byte_sad #(.W(W)) u_sad (
    .a_i(a_i), .b_i(b_i), .sad_o(sad_sum)
  );

  logic [W-1:0]  nxt_res;
  logic          nxt_ovf;
  logic [NB-1:0] nxt_ge;

  always_comb begin
    nxt_res = '0;
    nxt_ovf = 1'b0;
    nxt_ge  = '0;
    case (alu_op_e'(op_i))
      OP_ADD:  begin nxt_res = add_sum; nxt_ge = add_ge; end
      OP_QADD: begin nxt_res = q_sum;   nxt_ovf = q_sat; end
      OP_MAC:  begin nxt_res = mac_sum; nxt_ovf = mac_ovf; end
      OP_SAD:  nxt_res = sad_sum;
      OP_SADA: nxt_res = c_i + sad_sum;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      ovf_o     <= 1'b0;
      lane_ge_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= nxt_res;
        ovf_o     <= nxt_ovf;
        lane_ge_o <= nxt_ge;
      end
    end
  end

  // R2: idle cycles keep the result register
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(result_o) && !valid_o));
  // R4: two non-negative operands never give a negative saturated sum
  a_r4_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd1 && !a_i[W-1] && !b_i[W-1]) |=> !result_o[W-1]);
  // R5: two negative operands never give a non-negative saturated sum
  a_r5_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd1 && a_i[W-1] && b_i[W-1]) |=> result_o[W-1]);
  // R10: byte SAD never flags overflow and fits in 10 bits
  a_r10_sad_range: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd3) |=> (!ovf_o && result_o <= W'(255 * NB)));
  // R12: ge bits only come from the packed add
  a_r12_ge_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i != 3'd0) |=> (lane_ge_o == '0));
endmodule

// File: tb/dsp_simd_alu_bench.sv
module dsp_simd_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  lane_i = '0;
  logic        hi_a_i = 1'b0, hi_b_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;
  logic [3:0]  lane_ge_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsp_simd_alu u_dsp_simd_alu (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .lane_i(lane_i),
    .hi_a_i(hi_a_i), .hi_b_i(hi_b_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .result_o(result_o), .ovf_o(ovf_o), .lane_ge_o(lane_ge_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic launch(input logic [2:0] op, input logic [1:0] ln, input logic ha,
                        input logic hb, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; lane_i = ln; hi_a_i = ha; hi_b_i = hb;
    a_i = a; b_i = b; c_i = c;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] r, input logic f,
                            input logic [3:0] ge);
    chk({req, " result"}, result_o, r);
    chk({req, " ovf"}, {31'd0, ovf_o}, {31'd0, f});
    chk({req, " ge"}, {28'd0, lane_ge_o}, {28'd0, ge});
    chk({req, " valid"}, {31'd0, valid_o}, 32'd1);
  endtask

  task automatic t_r1_reset();
    repeat (3) @(negedge clk);
    chk("R1 result", result_o, 32'd0);
    chk("R1 flags", {26'd0, ovf_o, lane_ge_o, valid_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_r3_wrap_add();
    launch(3'd0, 2'b00, 0, 0, 32'h7000_0000, 32'h7FFF_FFFF, 0);
    expect_out("R3 wrap", 32'hEFFF_FFFF, 1'b0, 4'b0000);
    launch(3'd0, 2'b00, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0);
    expect_out("R3 carry", 32'h0000_0000, 1'b0, 4'b0001);
  endtask

  task automatic t_r2_hold();
    @(negedge clk);
    a_i = 32'h1234_5678; b_i = 32'h1111_1111; op_i = 3'd3;
    @(negedge clk);
    chk("R2 hold result", result_o, 32'h0000_0000);
    chk("R2 valid low", {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_r4_r5_sat();
    launch(3'd1, 2'b00, 0, 0, 32'h7000_0000, 32'h7FFF_FFFF, 0);
    expect_out("R4 pos clamp", 32'h7FFF_FFFF, 1'b1, 4'b0000);
    launch(3'd1, 2'b00, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    expect_out("R5 neg clamp", 32'h8000_0000, 1'b1, 4'b0000);
    launch(3'd1, 2'b00, 0, 0, 32'h0000_0005, 32'hFFFF_FFFD, 0);
    expect_out("R5 exact", 32'h0000_0002, 1'b0, 4'b0000);
  endtask

  task automatic t_r6_half_lanes();
    launch(3'd0, 2'b01, 0, 0, 32'h0001_FFFF, 32'h0001_0001, 0);
    expect_out("R6 low carry", 32'h0002_0000, 1'b0, 4'b0001);
    launch(3'd0, 2'b01, 0, 0, 32'hFFFF_0000, 32'h0001_0000, 0);
    expect_out("R6 high carry", 32'h0000_0000, 1'b0, 4'b0010);
  endtask

  task automatic t_r7_byte_lanes();
    launch(3'd0, 2'b10, 0, 0, 32'hFF80_01FF, 32'h0180_0101, 0);
    expect_out("R7 bytes", 32'h0000_0200, 1'b0, 4'b1101);
    launch(3'd0, 2'b11, 0, 0, 32'h00FF_00FF, 32'h0001_0001, 0);
    expect_out("R7 bytes alt", 32'h0000_0000, 1'b0, 4'b0101);
  endtask

  task automatic t_r8_r9_mac();
    // a: hi=3 lo=-2 ; b: hi=5 lo=7 ; c=100
    launch(3'd2, 2'b00, 1, 1, 32'h0003_FFFE, 32'h0005_0007, 32'd100);
    expect_out("R8 hi*hi", 32'd115, 1'b0, 4'b0000);
    launch(3'd2, 2'b00, 0, 0, 32'h0003_FFFE, 32'h0005_0007, 32'd100);
    expect_out("R8 lo*lo", 32'd86, 1'b0, 4'b0000);
    launch(3'd2, 2'b00, 1, 0, 32'h0003_FFFE, 32'h0005_0007, 32'd100);
    expect_out("R8 hi*lo", 32'd121, 1'b0, 4'b0000);
    launch(3'd2, 2'b00, 0, 1, 32'h0003_FFFE, 32'h0005_0007, 32'd100);
    expect_out("R8 lo*hi", 32'd90, 1'b0, 4'b0000);
    launch(3'd2, 2'b00, 1, 1, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000);
    expect_out("R9 overflow", 32'h8000_0000, 1'b1, 4'b0000);
  endtask

  task automatic t_r10_r11_sad();
    launch(3'd3, 2'b00, 0, 0, 32'h10FF_0080, 32'h2000_FF80, 32'hFFFF_FFFF);
    expect_out("R10 sad", 32'h0000_020E, 1'b0, 4'b0000);
    launch(3'd4, 2'b00, 0, 0, 32'h10FF_0080, 32'h2000_FF80, 32'hFFFF_FFFF);
    expect_out("R11 sada wrap", 32'h0000_020D, 1'b0, 4'b0000);
  endtask

  task automatic t_r12_reserved();
    launch(3'd0, 2'b10, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    launch(3'd5, 2'b10, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1);
    expect_out("R12 op5", 32'd0, 1'b0, 4'b0000);
    launch(3'd7, 2'b00, 1, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7);
    expect_out("R12 op7", 32'd0, 1'b0, 4'b0000);
  endtask

  initial begin
    t_r1_reset();
    t_r2_hold();
    t_r3_wrap_add();
    t_r4_r5_sat();
    t_r6_half_lanes();
    t_r7_byte_lanes();
    t_r8_r9_mac();
    t_r10_r11_sad();
    t_r12_reserved();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule